// File: doc/BRIEF.md
# General Register Bus Datapath

This block is an 8-bit execution datapath. It holds seven general registers and one shared arithmetic and logic unit. A 14-bit control word arrives on an input port in every clock cycle and tells the block what to do. Two source multiplexers each place either a register or the external data input onto an operand bus. The ALU combines the two buses, and its result appears on the external data output in the same cycle. At the next rising edge the result is written into at most one destination register.

The same rising edge also loads four status flags from that result: carry, sign, zero and overflow. The block is intended to sit under a sequencer or control store that supplies the control words. Instruction fetch and sequencing are handled outside the block.

Destination code zero writes no register. It is used to send a result to the output without disturbing any stored state. Source code zero selects the external input, which is how constants and memory data enter the register set.

Top module: `gpr_bus_datapath`

## Requirements
- R1: While `rst_n` is low, all seven registers and all four flags are cleared. After release, reading any register returns 8'h00.
- R2: The control word fields are packed as follows: bits [13:11] are the A source, bits [10:8] are the B source, bits [7:5] are the destination, and bits [4:0] are the opcode.
- R3: A source code of 3'd0 puts `ext_in` on that operand bus. Source codes 3'd1 to 3'd7 put registers 1 to 7 on that bus.
- R4: `ext_out` shows the ALU result for the current control word and operands combinationally, in the same cycle, with no register in between.
- R5: A destination code d in the range 1 to 7 loads register d with `ext_out` at the next rising edge. All other registers keep their values.
- R6: Destination code 3'd0 modifies no register. The result is still driven on `ext_out`.
- R7: The arithmetic opcodes are defined as follows. 5'h00 passes A. 5'h01 gives A+1. 5'h02 gives A+B. 5'h05 gives A+~B+1. 5'h06 gives A-1. Any opcode not listed here or in R8 passes A, with the flags computed as A+0.
- R8: The logic opcodes are defined as follows. 5'h08 gives A AND B. 5'h0A gives A OR B. 5'h0C gives A XOR B. 5'h0E gives NOT A. 5'h10 gives A shifted right by one, with 0 entering at bit 7. 5'h18 gives A shifted left by one, with 0 entering at bit 0.
- R9: For arithmetic opcodes, the carry flag is the carry out of bit 7, and the overflow flag is the XOR of the carry into bit 7 and the carry out of bit 7. For logic opcodes, both flags are 0. Example: 8'hF0 minus 8'h14 gives 8'hDC with carry 1, sign 1, overflow 0 and zero 0.
- R10: At each rising edge out of reset, the sign flag takes bit 7 of the current result and the zero flag is set when the result is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | A source, B source, destination and opcode fields |
| ext_in | input | 8 | External data operand, selected by source code 0 |
| ext_out | output | 8 | ALU result of the current cycle |
| flag_c | output | 1 | Registered carry flag |
| flag_s | output | 1 | Registered sign flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The result on `ext_out` is due in the same cycle as its control word. The bench therefore samples it a short time after driving the inputs on the falling edge, before the next rising edge arrives. The flags and the register writes are due one rising edge later. The flags are sampled shortly after that edge. Each register write is confirmed in a later cycle by a transfer control word that routes the register back out to `ext_out`.

// File: rtl/gpr_dp_pkg.sv
package gpr_dp_pkg;

  localparam int OPR_W = 5;

  typedef enum logic [OPR_W-1:0] {
    OP_PASS = 5'h00,
    OP_INC  = 5'h01,
    OP_ADD  = 5'h02,
    OP_SUB  = 5'h05,
    OP_DEC  = 5'h06,
    OP_AND  = 5'h08,
    OP_OR   = 5'h0A,
    OP_XOR  = 5'h0C,
    OP_NOT  = 5'h0E,
    OP_SHR  = 5'h10,
    OP_SHL  = 5'h18
  } opr_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

endpackage

// File: rtl/gpr_src_mux.sv
module gpr_src_mux #(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  parameter int SEL_W  = 3
) (
  input  logic [NREG:1][DATA_W-1:0] regs,
  input  logic [DATA_W-1:0]         ext_in,
  input  logic [SEL_W-1:0]          sel,
  output logic [DATA_W-1:0]         bus_out
);

  // Code 0 selects the external input; codes 1..NREG select a register.
  always_comb begin
    bus_out = ext_in;
    for (int i = 1; i <= NREG; i++) begin
      if (sel == SEL_W'(i)) bus_out = regs[i];
    end
  end

endmodule

// File: rtl/gpr_alu.sv
module gpr_alu
  import gpr_dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [OPR_W-1:0]  opr,
  output logic [DATA_W-1:0] result,
  output flags_t            flags_nxt
);

  logic [DATA_W-1:0] b_op;
  logic              cin;
  logic              logic_op;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] lo_sum;
  logic [1:0]        hi_sum;
  logic              c_msb_in;
  logic              c_out;

  // Operand conditioning and opcode decode
  always_comb begin
    b_op      = '0;
    cin       = 1'b0;
    logic_op  = 1'b0;
    logic_res = a;
    unique case (opr)
      OP_INC: cin = 1'b1;
      OP_ADD: b_op = b;
      OP_SUB: begin b_op = ~b; cin = 1'b1; end
      OP_DEC: b_op = '1;
      OP_AND: begin logic_op = 1'b1; logic_res = a & b; end
      OP_OR:  begin logic_op = 1'b1; logic_res = a | b; end
      OP_XOR: begin logic_op = 1'b1; logic_res = a ^ b; end
      OP_NOT: begin logic_op = 1'b1; logic_res = ~a; end
      OP_SHR: begin logic_op = 1'b1; logic_res = {1'b0, a[DATA_W-1:1]}; end
      OP_SHL: begin logic_op = 1'b1; logic_res = {a[DATA_W-2:0], 1'b0}; end
      default: ;
    endcase
  end

  // The adder is split at the top bit so that the carry into it can be seen.
  always_comb begin
    lo_sum   = {1'b0, a[DATA_W-2:0]} + {1'b0, b_op[DATA_W-2:0]} + {{(DATA_W-1){1'b0}}, cin};
    c_msb_in = lo_sum[DATA_W-1];
    hi_sum   = {1'b0, a[DATA_W-1]} + {1'b0, b_op[DATA_W-1]} + {1'b0, c_msb_in};
    c_out    = hi_sum[1];
  end

  always_comb begin
    if (logic_op) begin
      result      = logic_res;
      flags_nxt.c = 1'b0;
      flags_nxt.v = 1'b0;
    end else begin
      result      = {hi_sum[0], lo_sum[DATA_W-2:0]};
      flags_nxt.c = c_out;
      flags_nxt.v = c_out ^ c_msb_in;
    end
    flags_nxt.s = result[DATA_W-1];
    flags_nxt.z = (result == '0);
  end

endmodule

// File: rtl/gpr_regfile.sv
module gpr_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  parameter int SEL_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NREG:1][DATA_W-1:0] regs_q
);

  logic [NREG:1] wr_en;

  // Destination decoder; code 0 enables nothing.
  always_comb begin
    wr_en = '0;
    for (int i = 1; i <= NREG; i++) begin
      if (wr_sel == SEL_W'(i)) wr_en[i] = 1'b1;
    end
  end

  for (genvar g = 1; g <= NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_en[g]) begin
        regs_q[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/gpr_bus_datapath.sv
module gpr_bus_datapath
  import gpr_dp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  localparam int SEL_W = $clog2(NREG + 1),
  localparam int CW_W  = 3 * SEL_W + OPR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] ext_out,
  output logic              flag_c,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_v
);

  localparam int A_LSB = 2 * SEL_W + OPR_W;
  localparam int B_LSB = SEL_W + OPR_W;
  localparam int D_LSB = OPR_W;

  logic [SEL_W-1:0]          sel_a;
  logic [SEL_W-1:0]          sel_b;
  logic [SEL_W-1:0]          sel_d;
  logic [OPR_W-1:0]          opr;
  logic [NREG:1][DATA_W-1:0] regs_q;
  logic [DATA_W-1:0]         bus_a;
  logic [DATA_W-1:0]         bus_b;
  logic [DATA_W-1:0]         alu_res;
  flags_t                    flags_d;
  flags_t                    flags_q;

  assign sel_a = ctrl_word[A_LSB +: SEL_W];
  assign sel_b = ctrl_word[B_LSB +: SEL_W];
  assign sel_d = ctrl_word[D_LSB +: SEL_W];
  assign opr   = ctrl_word[OPR_W-1:0];

  gpr_src_mux #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_mux_a (
    .regs(regs_q), .ext_in(ext_in), .sel(sel_a), .bus_out(bus_a)
  );

  gpr_src_mux #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_mux_b (
    .regs(regs_q), .ext_in(ext_in), .sel(sel_b), .bus_out(bus_b)
  );

  gpr_alu #(.DATA_W(DATA_W)) u_alu (
    .a(bus_a), .b(bus_b), .opr(opr), .result(alu_res), .flags_nxt(flags_d)
  );

  gpr_regfile #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_sel(sel_d), .wr_data(alu_res), .regs_q(regs_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign ext_out = alu_res;
  assign flag_c  = flags_q.c;
  assign flag_s  = flags_q.s;
  assign flag_z  = flags_q.z;
  assign flag_v  = flags_q.v;

endmodule

// File: rtl/gpr_bus_datapath_chk.sv
module gpr_bus_datapath_chk #(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  parameter int SEL_W  = 3,
  parameter int CW_W   = 14
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [CW_W-1:0]           ctrl_word,
  input logic [DATA_W-1:0]         ext_in,
  input logic [DATA_W-1:0]         ext_out,
  input logic                      flag_c,
  input logic                      flag_s,
  input logic                      flag_z,
  input logic                      flag_v,
  input logic [NREG:1][DATA_W-1:0] regs_q
);

  localparam int OW = CW_W - 3 * SEL_W;

  logic [SEL_W-1:0] f_a;
  logic [SEL_W-1:0] f_d;
  logic [OW-1:0]    f_op;
  logic             is_logic;

  assign f_a      = ctrl_word[CW_W-1 -: SEL_W];
  assign f_d      = ctrl_word[OW +: SEL_W];
  assign f_op     = ctrl_word[OW-1:0];
  assign is_logic = (f_op == OW'(5'h08)) || (f_op == OW'(5'h0A)) || (f_op == OW'(5'h0C)) ||
                    (f_op == OW'(5'h0E)) || (f_op == OW'(5'h10)) || (f_op == OW'(5'h18));

  assert_ext_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (f_a == '0 && f_op == '0) |-> ext_out == ext_in);

  assert_dest_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (f_d != '0) |=> regs_q[$past(f_d)] == $past(ext_out));

  assert_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (f_d == '0) |=> $stable(regs_q));

  assert_logic_cv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |=> (!flag_c && !flag_v));

  assert_sign_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> flag_s == $past(ext_out[DATA_W-1]));

  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> flag_z == ($past(ext_out) == '0));

endmodule

bind gpr_bus_datapath gpr_bus_datapath_chk #(
  .DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W), .CW_W(CW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_in(ext_in),
  .ext_out(ext_out), .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z),
  .flag_v(flag_v), .regs_q(regs_q)
);

// File: tb/gpr_bus_datapath_bench.sv
module gpr_bus_datapath_bench;

  logic        clk;
  logic        rst_n;
  logic [13:0] ctrl_word;
  logic [7:0]  ext_in;
  logic [7:0]  ext_out;
  logic        flag_c, flag_s, flag_z, flag_v;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  gpr_bus_datapath u_gpr_bus_datapath (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_in(ext_in),
    .ext_out(ext_out), .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z),
    .flag_v(flag_v)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Each vector: {A src, B src, dest, opcode, ext_in, expected out, expected C S Z V}
  localparam int NV = 21;
  localparam logic [33:0] VEC [NV] = '{
    {3'd0, 3'd0, 3'd1, 5'h00, 8'hF0, 8'hF0, 4'b0100},  // R1 <- F0
    {3'd0, 3'd0, 3'd2, 5'h00, 8'h14, 8'h14, 4'b0000},  // R2 <- 14
    {3'd1, 3'd2, 3'd3, 5'h05, 8'h00, 8'hDC, 4'b1100},  // R3 <- R1-R2
    {3'd3, 3'd0, 3'd0, 5'h0C, 8'hFF, 8'h23, 4'b0000},  // xor with ext, no dest
    {3'd3, 3'd0, 3'd0, 5'h00, 8'h00, 8'hDC, 4'b0100},  // R3 unchanged
    {3'd0, 3'd0, 3'd4, 5'h00, 8'h7F, 8'h7F, 4'b0000},  // R4 <- 7F
    {3'd4, 3'd0, 3'd5, 5'h02, 8'h01, 8'h80, 4'b0101},  // R5 <- 7F+1 overflow
    {3'd0, 3'd0, 3'd6, 5'h01, 8'hFF, 8'h00, 4'b1010},  // R6 <- FF+1
    {3'd0, 3'd0, 3'd7, 5'h06, 8'h00, 8'hFF, 4'b0100},  // R7 <- 00-1
    {3'd1, 3'd2, 3'd0, 5'h08, 8'h00, 8'h10, 4'b0000},  // and
    {3'd1, 3'd2, 3'd0, 5'h0A, 8'h00, 8'hF4, 4'b0100},  // or
    {3'd2, 3'd0, 3'd0, 5'h0E, 8'h00, 8'hEB, 4'b0100},  // complement
    {3'd1, 3'd0, 3'd0, 5'h10, 8'h00, 8'h78, 4'b0000},  // shift right
    {3'd1, 3'd0, 3'd0, 5'h18, 8'h00, 8'hE0, 4'b0100},  // shift left
    {3'd5, 3'd0, 3'd0, 5'h1F, 8'h00, 8'h80, 4'b0100},  // unlisted opcode
    {3'd4, 3'd0, 3'd0, 5'h05, 8'h80, 8'hFF, 4'b0101},  // 7F-80 overflow
    {3'd6, 3'd0, 3'd0, 5'h00, 8'h55, 8'h00, 4'b0010},  // read R6
    {3'd7, 3'd0, 3'd0, 5'h00, 8'h00, 8'hFF, 4'b0100},  // read R7
    {3'd5, 3'd0, 3'd0, 5'h00, 8'h00, 8'h80, 4'b0100},  // read R5
    {3'd1, 3'd1, 3'd1, 5'h02, 8'h00, 8'hE0, 4'b1100},  // R1 <- R1+R1
    {3'd1, 3'd0, 3'd0, 5'h00, 8'h00, 8'hE0, 4'b0100}   // read R1
  };

  // Drive on the falling edge; result is due in the same cycle, flags after the next rise.
  task automatic step(input logic [13:0] cw, input logic [7:0] din,
                      input logic [7:0] exp_out, input logic [3:0] exp_fl,
                      input string tag);
    @(negedge clk);
    ctrl_word = cw;
    ext_in    = din;
    #2;
    checks++;
    if (ext_out !== exp_out) begin
      errors++;
      $display("FAIL %s out: actual=%h expected=%h", tag, ext_out, exp_out);
    end
    @(posedge clk);
    #2;
    checks++;
    if ({flag_c, flag_s, flag_z, flag_v} !== exp_fl) begin
      errors++;
      $display("FAIL %s flags CSZV: actual=%b expected=%b", tag,
               {flag_c, flag_s, flag_z, flag_v}, exp_fl);
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    ctrl_word = '0;
    ext_in    = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({flag_c, flag_s, flag_z, flag_v} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset flags: actual=%b expected=0000", {flag_c, flag_s, flag_z, flag_v});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int r = 1; r <= 7; r++) begin
      step({3'(r), 3'd0, 3'd0, 5'h00}, 8'hAA, 8'h00, 4'b0010, "R1 reset reg");
    end

    // Vector walk covering R2 R3 R4 R5 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][33:20], VEC[i][19:12], VEC[i][11:4], VEC[i][3:0], "R2/R3/R4/R7/R8/R9/R10 vec");
    end

    // R5: write R2 only, other registers untouched
    step({3'd0, 3'd0, 3'd2, 5'h00}, 8'h3C, 8'h3C, 4'b0000, "R5 load");
    step({3'd2, 3'd0, 3'd0, 5'h00}, 8'h00, 8'h3C, 4'b0000, "R5 readback");
    step({3'd3, 3'd0, 3'd0, 5'h00}, 8'h00, 8'hDC, 4'b0100, "R5 neighbour");

    // R6: destination 0 with a new value leaves R2 intact
    step({3'd0, 3'd0, 3'd0, 5'h00}, 8'h99, 8'h99, 4'b0100, "R6 no dest");
    step({3'd2, 3'd0, 3'd0, 5'h00}, 8'h00, 8'h3C, 4'b0000, "R6 hold");

    // R3 on the B side: ext minus a register
    step({3'd0, 3'd2, 3'd0, 5'h05}, 8'h3C, 8'h00, 4'b1010, "R3 B ext/reg");

    // R1: reset in the middle of a run clears stored state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step({3'd2, 3'd0, 3'd0, 5'h00}, 8'h00, 8'h00, 4'b0010, "R1 mid-run reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule